// File: doc/BRIEF.md
# Response Check and Retry Controller

This block sits behind a serial-link master that has just sent a command frame and captured the reply. It takes the reply's 4-bit tag, its 4-bit check code and up to 32 data bits. It checks the CRC and decodes the two-bit acknowledge code. It then either reports a final status to the host or runs a recovery sequence. A recovery sequence asks a separate frame sender for bursts of idle clocks and for poll or terminate frames. Framing the commands and driving the wire belong to the frame sender, which is reached through a valid/ready request port.

The host starts an operation with a one-cycle `req_valid` that gives the expected reply size and the target slave. It then feeds every reply it receives through `rsp_valid`. When the operation is over, the block gives a one-cycle `done` with a 2-bit status. Status codes are OK=0, NODEV=1, IOERR=2 and RETRY=3. The status and the returned data stay on the outputs until the next completion. The retry limit, the busy limit and the two idle-clock burst lengths are parameters.

Top module: `resp_retry_ctrl`

## Requirements
- R1: After reset `done` and `snd_valid` are 0, `status` is OK (0) and `rdata` is 0.
- R2: The CRC uses polynomial x^4+x+1 with a zero initial value, fed MSB first. It covers a leading 1 bit, the 4 tag bits, the data bits, then the 4 received check bits, and a zero remainder means the reply is good. Data bits are `rsp_data[n-1:0]`, and they count only when the acknowledge code (`rsp_tag[1:0]`) is ACK (0) and n>0. The size code gives n: 0=0, 1=8, 2=16, 3=32. A good ACK completes with status OK and `rdata` equal to the data masked to n bits. `done` is high in the cycle after `rsp_valid`.
- R3: A reply that fails the CRC with tag and check bits both 4'hF, or both 4'h0, completes with status NODEV (1).
- R4: Any other CRC failure asks for EPOLL_CLOCKS idle clocks (kind 0). It then asks for an error-poll frame (kind 2) to `req_slave`, and the next reply is checked.
- R5: The block allows at most RETRY_MAX error polls per operation. One more CRC failure after that completes with status IOERR (2).
- R6: A good reply with code BUSY (1) asks for DPOLL_CLOCKS idle clocks, then a data-poll frame (kind 1), and the next reply is checked.
- R7: After BUSY_MAX data polls in one operation, a further BUSY asks for DPOLL_CLOCKS idle clocks and then a terminate frame (kind 3). Once the sender accepts that frame, the operation completes with IOERR.
- R8: A good reply with code 2 completes with IOERR. A good reply with code 3 completes with RETRY (3). On any non-OK status `rdata` is 0.
- R9: Each idle-clock request carries between 1 and 255 clocks. The requests of one burst add up to the burst length.
- R10: `done` is a one-cycle pulse. `status` and `rdata` hold until the next completion. `rsp_valid` outside a wait for a reply, and `req_valid` during an operation, have no effect.
- R11: While `snd_valid` is high and `snd_ready` is low, `snd_valid`, `snd_kind`, `snd_count` and `snd_slave` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an operation (accepted when idle) |
| req_size | input | 2 | Expected reply data size code |
| req_slave | input | 2 | Slave id for poll and terminate frames |
| rsp_valid | input | 1 | A reply is present on the reply inputs |
| rsp_tag | input | 4 | Reply tag; low two bits are the acknowledge code |
| rsp_crc | input | 4 | Received check bits |
| rsp_data | input | 32 | Reply data, right-aligned |
| snd_valid | output | 1 | Request to the frame sender |
| snd_ready | input | 1 | Frame sender accepts the request |
| snd_kind | output | 2 | 0 idle clocks, 1 data poll, 2 error poll, 3 terminate |
| snd_count | output | 8 | Idle clocks in this request |
| snd_slave | output | 2 | Slave id for the frame |
| done | output | 1 | Operation complete (one cycle) |
| status | output | 2 | Final status |
| rdata | output | 32 | Returned data, right-aligned |

## Verification
The bound checker watches the protocol-level rules on every cycle. These are the single-cycle `done` and the held status when nothing could complete an operation. They also cover request stability under back-pressure, non-empty idle chunks, and that every poll or terminate frame is preceded by accepted idle clocks. The bench scenarios are the only place to show the CRC arithmetic, the NODEV special cases and the exact burst lengths. They also cover the point at which the retry and busy limits cut over to IOERR, and right-aligned data masking. These depend on whole reply sequences checked against a reference division.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    typedef enum logic [1:0] {ACK_OK = 2'd0, ACK_BUSY = 2'd1, ACK_ERRA = 2'd2, ACK_ERRC = 2'd3} ack_e;
    typedef enum logic [1:0] {ST_OK = 2'd0, ST_NODEV = 2'd1, ST_IOERR = 2'd2, ST_RETRY = 2'd3} stat_e;
    typedef enum logic [1:0] {SND_IDLE = 2'd0, SND_DPOLL = 2'd1, SND_EPOLL = 2'd2, SND_TERM = 2'd3} snd_e;
    typedef enum logic [1:0] {F_IDLE, F_WAIT, F_CLK, F_FRAME} fsm_e;

    // data bits carried by a size code
    function automatic int size_bits(logic [1:0] code);
        case (code)
            2'd1:    return 8;
            2'd2:    return 16;
            2'd3:    return 32;
            default: return 0;
        endcase
    endfunction

    // one serial step of x^4+x+1, MSB first
    function automatic logic [3:0] crc4_step(logic [3:0] c, logic b);
        logic fb;
        fb = c[3] ^ b;
        return {c[2:0], 1'b0} ^ {2'b00, fb, fb};
    endfunction

endpackage

// File: rtl/rcr_check.sv
module rcr_check
    import rcr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    tag,
    input  logic [3:0]    crc,
    input  logic [DW-1:0] data,
    input  logic [1:0]    size,
    output logic          good,
    output logic          nodev,
    output logic [1:0]    code,
    output logic [DW-1:0] payload
);
    int   nbits;
    logic use_data;
    logic [3:0] rem;

    always_comb begin
        nbits    = size_bits(size);
        if (nbits > DW) nbits = DW;
        use_data = (tag[1:0] == ACK_OK) && (nbits != 0);
        rem      = crc4_step(4'd0, 1'b1);
        for (int i = 3; i >= 0; i--) rem = crc4_step(rem, tag[i]);
        for (int i = DW - 1; i >= 0; i--) begin
            if (use_data && (i < nbits)) rem = crc4_step(rem, data[i]);
        end
        for (int i = 3; i >= 0; i--) rem = crc4_step(rem, crc[i]);
        good  = (rem == 4'd0);
        nodev = !good && (({tag, crc} == 8'hFF) || ({tag, crc} == 8'h00));
        code  = tag[1:0];
        for (int i = 0; i < DW; i++) payload[i] = data[i] & (i < nbits);
    end
endmodule

// File: rtl/rcr_chunk.sv
module rcr_chunk #(
    parameter int CW        = 9,
    parameter int CHUNK_MAX = 255,
    parameter int CHW       = 8
) (
    input  logic [CW-1:0]  remain,
    output logic [CHW-1:0] chunk,
    output logic [CW-1:0]  rest
);
    logic over;

    always_comb begin
        over = (32'(remain) > CHUNK_MAX);
        if (over) begin
            chunk = CHW'(CHUNK_MAX);
            rest  = remain - CW'(CHUNK_MAX);
        end else begin
            chunk = CHW'(remain);
            rest  = '0;
        end
    end
endmodule

// File: rtl/rcr_seq.sv
module rcr_seq
    import rcr_pkg::*;
#(
    parameter int RETRY_MAX    = 3,
    parameter int BUSY_MAX     = 16,
    parameter int EPOLL_CLOCKS = 50,
    parameter int DPOLL_CLOCKS = 21,
    parameter int DW           = 32,
    parameter int CW           = 6,
    parameter int CHW          = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_size,
    input  logic [1:0]     req_slave,
    input  logic           rsp_valid,
    input  logic           chk_good,
    input  logic           chk_nodev,
    input  logic [1:0]     chk_code,
    input  logic [DW-1:0]  chk_payload,
    input  logic           snd_ready,
    input  logic [CHW-1:0] chunk_len,
    input  logic [CW-1:0]  chunk_rest,
    output logic [CW-1:0]  remain,
    output logic [1:0]     size_cur,
    output logic           snd_valid,
    output logic [1:0]     snd_kind,
    output logic [CHW-1:0] snd_count,
    output logic [1:0]     snd_slave,
    output logic           done,
    output logic [1:0]     status,
    output logic [DW-1:0]  rdata
);
    localparam int RW = (RETRY_MAX > 0) ? $clog2(RETRY_MAX + 1) : 1;
    localparam int BW = (BUSY_MAX > 0) ? $clog2(BUSY_MAX + 1) : 1;

    typedef struct packed {
        fsm_e          st;
        logic [RW-1:0] retries;
        logic [BW-1:0] busy;
        logic [CW-1:0] remain;
        snd_e          frame;
        logic [1:0]    size;
        logic [1:0]    slave;
        stat_e         status;
        logic [DW-1:0] rdata;
        logic          done;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            F_IDLE: begin
                if (req_valid) begin
                    d.st      = F_WAIT;
                    d.size    = req_size;
                    d.slave   = req_slave;
                    d.retries = '0;
                    d.busy    = '0;
                end
            end
            F_WAIT: begin
                if (rsp_valid) begin
                    if (!chk_good) begin
                        if (chk_nodev || (32'(q.retries) >= RETRY_MAX)) begin
                            d.st     = F_IDLE;
                            d.done   = 1'b1;
                            d.status = chk_nodev ? ST_NODEV : ST_IOERR;
                            d.rdata  = '0;
                        end else begin
                            d.retries = q.retries + RW'(1);
                            d.frame   = SND_EPOLL;
                            d.remain  = CW'(EPOLL_CLOCKS);
                            d.st      = (EPOLL_CLOCKS == 0) ? F_FRAME : F_CLK;
                        end
                    end else begin
                        case (ack_e'(chk_code))
                            ACK_OK: begin
                                d.st     = F_IDLE;
                                d.done   = 1'b1;
                                d.status = ST_OK;
                                d.rdata  = chk_payload;
                            end
                            ACK_BUSY: begin
                                d.remain = CW'(DPOLL_CLOCKS);
                                d.st     = (DPOLL_CLOCKS == 0) ? F_FRAME : F_CLK;
                                if (32'(q.busy) >= BUSY_MAX) begin
                                    d.frame = SND_TERM;
                                end else begin
                                    d.frame = SND_DPOLL;
                                    d.busy  = q.busy + BW'(1);
                                end
                            end
                            ACK_ERRA: begin
                                d.st     = F_IDLE;
                                d.done   = 1'b1;
                                d.status = ST_IOERR;
                                d.rdata  = '0;
                            end
                            default: begin
                                d.st     = F_IDLE;
                                d.done   = 1'b1;
                                d.status = ST_RETRY;
                                d.rdata  = '0;
                            end
                        endcase
                    end
                end
            end
            F_CLK: begin
                if (snd_ready) begin
                    d.remain = chunk_rest;
                    if (chunk_rest == '0) d.st = F_FRAME;
                end
            end
            default: begin
                if (snd_ready) begin
                    if (q.frame == SND_TERM) begin
                        d.st     = F_IDLE;
                        d.done   = 1'b1;
                        d.status = ST_IOERR;
                        d.rdata  = '0;
                    end else begin
                        d.st = F_WAIT;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign remain    = q.remain;
    assign size_cur  = q.size;
    assign snd_valid = (q.st == F_CLK) || (q.st == F_FRAME);
    assign snd_kind  = (q.st == F_CLK) ? SND_IDLE : q.frame;
    assign snd_count = (q.st == F_CLK) ? chunk_len : '0;
    assign snd_slave = q.slave;
    assign done      = q.done;
    assign status    = q.status;
    assign rdata     = q.rdata;
endmodule

// File: rtl/resp_retry_ctrl.sv
module resp_retry_ctrl #(
    parameter int RETRY_MAX    = 3,
    parameter int BUSY_MAX     = 16,
    parameter int EPOLL_CLOCKS = 50,
    parameter int DPOLL_CLOCKS = 21,
    parameter int CHUNK_MAX    = 255,
    parameter int DATA_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_slave,
    input  logic              rsp_valid,
    input  logic [3:0]        rsp_tag,
    input  logic [3:0]        rsp_crc,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              snd_valid,
    input  logic              snd_ready,
    output logic [1:0]        snd_kind,
    output logic [7:0]        snd_count,
    output logic [1:0]        snd_slave,
    output logic              done,
    output logic [1:0]        status,
    output logic [DATA_W-1:0] rdata
);
    localparam int MAXCLK = (EPOLL_CLOCKS > DPOLL_CLOCKS) ? EPOLL_CLOCKS : DPOLL_CLOCKS;
    localparam int CW     = (MAXCLK > 0) ? $clog2(MAXCLK + 1) : 1;
    localparam int CHW    = 8;

    logic              good, nodev;
    logic [1:0]        code, size_cur;
    logic [DATA_W-1:0] payload;
    logic [CW-1:0]     remain, rest;
    logic [CHW-1:0]    chunk;

    rcr_check #(.DW(DATA_W)) check_i (
        .tag(rsp_tag), .crc(rsp_crc), .data(rsp_data), .size(size_cur),
        .good(good), .nodev(nodev), .code(code), .payload(payload)
    );

    rcr_chunk #(.CW(CW), .CHUNK_MAX(CHUNK_MAX), .CHW(CHW)) chunk_i (
        .remain(remain), .chunk(chunk), .rest(rest)
    );

    rcr_seq #(
        .RETRY_MAX(RETRY_MAX), .BUSY_MAX(BUSY_MAX), .EPOLL_CLOCKS(EPOLL_CLOCKS),
        .DPOLL_CLOCKS(DPOLL_CLOCKS), .DW(DATA_W), .CW(CW), .CHW(CHW)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
        .req_slave(req_slave), .rsp_valid(rsp_valid), .chk_good(good),
        .chk_nodev(nodev), .chk_code(code), .chk_payload(payload),
        .snd_ready(snd_ready), .chunk_len(chunk), .chunk_rest(rest),
        .remain(remain), .size_cur(size_cur), .snd_valid(snd_valid),
        .snd_kind(snd_kind), .snd_count(snd_count), .snd_slave(snd_slave),
        .done(done), .status(status), .rdata(rdata)
    );
endmodule

// File: rtl/rcr_chk.sv
module rcr_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rsp_valid,
    input logic          snd_valid,
    input logic          snd_ready,
    input logic [1:0]    snd_kind,
    input logic [7:0]    snd_count,
    input logic [1:0]    snd_slave,
    input logic          done,
    input logic [1:0]    status,
    input logic [DW-1:0] rdata
);
    logic       seen_q;
    logic [1:0] last_kind_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            last_kind_q <= 2'd0;
        end else if (snd_valid && snd_ready) begin
            seen_q      <= 1'b1;
            last_kind_q <= snd_kind;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid && !(snd_valid && snd_ready)) |=> (!done && $stable(status) && $stable(rdata)));

    // R11
    snd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && !snd_ready) |=> (snd_valid && $stable(snd_kind) && $stable(snd_count) && $stable(snd_slave)));

    // R9
    chunk_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && snd_kind == 2'd0) |-> (snd_count != 8'd0));

    // R6
    frame_after_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && snd_kind != 2'd0) |-> (seen_q && last_kind_q == 2'd0));

    // R10
    done_quiet_snd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !snd_valid);
endmodule

bind resp_retry_ctrl rcr_chk #(.DW(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .snd_valid(snd_valid),
    .snd_ready(snd_ready), .snd_kind(snd_kind), .snd_count(snd_count),
    .snd_slave(snd_slave), .done(done), .status(status), .rdata(rdata)
);

// File: tb/resp_retry_ctrl_tb_top.sv
`timescale 1ns/1ps
module resp_retry_ctrl_tb_top;
    localparam int RMAX = 2;
    localparam int BMAX = 3;
    localparam int EPC  = 300;
    localparam int DPC  = 21;

    localparam int K_ACK = 0, K_BUSY = 1, K_BAD = 2, K_ERRA = 3, K_ERRC = 4, K_FF = 5, K_00 = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_size = '0, req_slave = '0;
    logic        rsp_valid = 1'b0;
    logic [3:0]  rsp_tag = '0, rsp_crc = '0;
    logic [31:0] rsp_data = '0;
    logic        snd_ready = 1'b0;
    logic        snd_valid, done;
    logic [1:0]  snd_kind, snd_slave, status;
    logic [7:0]  snd_count;
    logic [31:0] rdata;

    int errors = 0, checks = 0;
    bit finished = 0;
    int script [0:31];
    int script_n;

    always #2 clk = ~clk;

    resp_retry_ctrl #(
        .RETRY_MAX(RMAX), .BUSY_MAX(BMAX), .EPOLL_CLOCKS(EPC), .DPOLL_CLOCKS(DPC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
        .req_slave(req_slave), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_crc(rsp_crc), .rsp_data(rsp_data), .snd_valid(snd_valid),
        .snd_ready(snd_ready), .snd_kind(snd_kind), .snd_count(snd_count),
        .snd_slave(snd_slave), .done(done), .status(status), .rdata(rdata)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    function automatic int nbits_of(logic [1:0] s);
        return (s == 2'd0) ? 0 : (s == 2'd1) ? 8 : (s == 2'd2) ? 16 : 32;
    endfunction

    // long division of the augmented message by 10011
    function automatic logic [3:0] ref_rem(logic [3:0] tag, logic [31:0] data, int nb);
        logic [44:0] m;
        logic [4:0]  r;
        int n;
        m = 45'd1; n = 1;
        m = (m << 4) | 45'(tag); n += 4;
        for (int i = nb - 1; i >= 0; i--) begin m = (m << 1) | 45'(data[i]); n++; end
        m = m << 4; n += 4;
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            r = {r[3:0], m[i]};
            if (r[4]) r = r ^ 5'b10011;
        end
        return r[3:0];
    endfunction

    function automatic logic [31:0] mask_of(int nb);
        return 32'((64'd1 << nb) - 64'd1);
    endfunction

    task automatic make_rsp(int k, logic [1:0] sz);
        logic [3:0] g;
        int nb;
        nb = nbits_of(sz);
        rsp_data = $urandom;
        case (k)
            K_ACK:  begin rsp_tag = {2'($urandom), 2'd0}; rsp_crc = ref_rem(rsp_tag, rsp_data, nb); end
            K_BUSY: begin rsp_tag = {2'($urandom), 2'd1}; rsp_crc = ref_rem(rsp_tag, rsp_data, 0); end
            K_ERRA: begin rsp_tag = {2'($urandom), 2'd2}; rsp_crc = ref_rem(rsp_tag, rsp_data, 0); end
            K_ERRC: begin rsp_tag = {2'($urandom), 2'd3}; rsp_crc = ref_rem(rsp_tag, rsp_data, 0); end
            K_BAD: begin
                rsp_tag = {2'($urandom), 1'b0, 1'($urandom)};
                g = ref_rem(rsp_tag, rsp_data, (rsp_tag[1:0] == 2'd0) ? nb : 0);
                do rsp_crc = 4'($urandom); while (rsp_crc == g || (rsp_tag == 4'h0 && rsp_crc == 4'h0));
            end
            K_FF:    begin rsp_tag = 4'hF; rsp_crc = 4'hF; end
            default: begin rsp_tag = 4'h0; rsp_crc = 4'h0; rsp_data = '0; end
        endcase
    endtask

    // feeds the sender port until done or a poll frame is accepted
    task automatic serve(output bit got_done, output int clocks, output int chunks,
                         output int frame, output int fsl, output bit chunk_bad);
        bit acc;
        got_done = 0; clocks = 0; chunks = 0; frame = -1; fsl = -1; chunk_bad = 0;
        for (int t = 0; t < 4000; t++) begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (done) begin got_done = 1; snd_ready = 1'b0; return; end
            if (snd_valid) begin
                acc = ($urandom % 4) != 0;
                snd_ready = acc;
                if (acc) begin
                    if (snd_kind == 2'd0) begin
                        clocks += int'(snd_count);
                        chunks++;
                        if (snd_count == 8'd0) chunk_bad = 1;
                    end else begin
                        frame = int'(snd_kind);
                        fsl = int'(snd_slave);
                        if (snd_kind != 2'd3) begin
                            @(negedge clk);
                            snd_ready = 1'b0;
                            return;
                        end
                    end
                end
            end else begin
                snd_ready = 1'b0;
            end
        end
    endtask

    task automatic run_op(logic [1:0] sz, logic [1:0] sl, string tagname);
        int  retries, busy, idx, k, exp_clk, exp_frame, exp_st, nb;
        int  clocks, chunks, frame, fsl;
        bit  fin, got_done, chunk_bad, good;
        logic [31:0] exp_data;
        string rq;
        @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_slave = sl;
        @(negedge clk);
        req_valid = 1'b0;
        retries = 0; busy = 0; idx = 0; fin = 0;
        nb = nbits_of(sz);
        exp_data = '0; exp_st = 0;
        while (!fin) begin
            k = (idx < script_n) ? script[idx] : K_ACK;
            idx++;
            make_rsp(k, sz);
            rsp_valid = 1'b1;
            good = ref_rem(rsp_tag, rsp_data, (rsp_tag[1:0] == 2'd0) ? nb : 0) == rsp_crc;
            exp_clk = 0; exp_frame = -1;
            if (!good) begin
                if ((rsp_tag == 4'hF && rsp_crc == 4'hF) || (rsp_tag == 4'h0 && rsp_crc == 4'h0)) begin
                    exp_st = 1; fin = 1; rq = "R3";
                end else if (retries == RMAX) begin
                    exp_st = 2; fin = 1; rq = "R5";
                end else begin
                    retries++; exp_clk = EPC; exp_frame = 2; rq = "R4";
                end
            end else begin
                case (rsp_tag[1:0])
                    2'd0: begin exp_st = 0; fin = 1; exp_data = rsp_data & mask_of(nb); rq = "R2"; end
                    2'd1: begin
                        exp_clk = DPC;
                        if (busy == BMAX) begin exp_frame = 3; exp_st = 2; fin = 1; rq = "R7"; end
                        else begin busy++; exp_frame = 1; rq = "R6"; end
                    end
                    2'd2: begin exp_st = 2; fin = 1; rq = "R8"; end
                    default: begin exp_st = 3; fin = 1; rq = "R8"; end
                endcase
            end
            serve(got_done, clocks, chunks, frame, fsl, chunk_bad);
            check(clocks == exp_clk, rq, {tagname, " idle clocks"}, clocks, exp_clk);
            check(frame == exp_frame, rq, {tagname, " frame kind"}, frame, exp_frame);
            if (exp_frame >= 0) check(fsl == int'(sl), rq, {tagname, " frame slave"}, fsl, sl);
            if (exp_clk > 0) begin
                check(!chunk_bad && chunks == (exp_clk + 254) / 255, "R9",
                      {tagname, " chunk count"}, chunks, (exp_clk + 254) / 255);
            end
            check(got_done == fin, rq, {tagname, " done"}, got_done, fin);
            if (fin && got_done) begin
                if (exp_st != 0) exp_data = '0;
                check(status == 2'(exp_st), rq, {tagname, " status"}, status, exp_st);
                check(rdata == exp_data, rq, {tagname, " rdata"}, rdata, exp_data);
                @(negedge clk);
                check(done == 1'b0, "R10", {tagname, " done pulse"}, done, 0);
            end
            if (!fin && got_done) fin = 1;
        end
    endtask

    task automatic set_script(int a, int b, int c, int d, int n);
        script[0] = a; script[1] = b; script[2] = c; script[3] = d; script_n = n;
    endtask

    initial begin
        logic [1:0] hold_st;
        logic [31:0] hold_d;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 0 && snd_valid == 0, "R1", "reset done/snd_valid", {done, snd_valid}, 0);
        check(status == 0 && rdata == 0, "R1", "reset status/rdata", rdata, 0);
        rst_n = 1'b1;

        for (int s = 0; s < 4; s++) begin
            set_script(K_ACK, 0, 0, 0, 1);
            run_op(2'(s), 2'(s), "R2 ack");
        end
        set_script(K_FF, 0, 0, 0, 1);        run_op(2'd3, 2'd1, "R3 ones");
        set_script(K_00, 0, 0, 0, 1);        run_op(2'd2, 2'd2, "R3 zeros");
        set_script(K_BAD, K_ACK, 0, 0, 2);   run_op(2'd3, 2'd3, "R4 crc retry");
        set_script(K_BAD, K_BAD, K_BAD, 0, 3); run_op(2'd1, 2'd0, "R5 crc limit");
        set_script(K_BUSY, K_ACK, 0, 0, 2);  run_op(2'd2, 2'd1, "R6 busy poll");
        set_script(K_BUSY, K_BUSY, K_BUSY, K_BUSY, 4); run_op(2'd3, 2'd2, "R7 busy limit");
        set_script(K_ERRA, 0, 0, 0, 1);      run_op(2'd3, 2'd0, "R8 erra");
        set_script(K_ERRC, 0, 0, 0, 1);      run_op(2'd3, 2'd3, "R8 errc");
        set_script(K_BUSY, K_ERRC, 0, 0, 2); run_op(2'd0, 2'd1, "R2 busy data excluded");

        // R10: replies and extra traffic while idle are ignored
        hold_st = status; hold_d = rdata;
        @(negedge clk);
        make_rsp(K_BAD, 2'd3);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(done == 0 && snd_valid == 0, "R10", "idle reply ignored", {done, snd_valid}, 0);
            @(negedge clk);
        end
        check(status == hold_st && rdata == hold_d, "R10", "status held", status, hold_st);

        for (int op = 0; op < 40; op++) begin
            script_n = 1 + ($urandom % 8);
            for (int i = 0; i < 32; i++) begin
                int r;
                r = $urandom % 16;
                script[i] = (r < 4) ? K_ACK : (r < 8) ? K_BUSY : (r < 12) ? K_BAD :
                            (r == 12) ? K_ERRA : (r == 13) ? K_ERRC : (r == 14) ? K_FF : K_00;
            end
            run_op(2'($urandom), 2'($urandom), "random");
        end
        finish_run();
    end
endmodule